// File: doc/BRIEF.md
# Custom-Precision Floating-Point Multiplier

This block multiplies two numbers held in a small floating-point format whose exponent and fraction widths are build parameters. Every word carries a two-bit class tag in its top bits that says whether the value is zero, a normal number, infinity or NaN. The special values therefore need no reserved exponent codes, and all exponent values from 0 to 2^EXP_W-1 are valid for normal numbers. A normal number has an implied leading one above its fraction, and subnormals do not exist. The product leaves in the same tagged layout, with a wider fraction field.

The datapath has no clock and no registers. It is sized for low area rather than short delay. One build option sets the output fraction width. In single mode it keeps one fraction bit more than the inputs. In extended mode it keeps the whole significand product except its leading one, so no rounding is needed. A second option picks round-to-nearest-even or plain truncation when bits must be dropped. An exponent that rises past the top of the range gives infinity. An exponent that falls below zero flushes the result to zero.

Top module: `cfp_mul`

## Requirements
- R1: Both operand words are laid out from the most significant bit down as a class tag (2 bits), a sign (1 bit), a biased exponent (EXP_W bits, bias 2^(EXP_W-1)-1) and a fraction (FRAC_W bits). The result word uses the same layout. Its fraction is FRAC_W+1 bits wide in single mode and 2*FRAC_W+1 bits wide in extended mode. The tag codes are 00 zero, 01 normal, 10 infinity and 11 NaN. A zero, infinity or NaN result has all-zero exponent and fraction fields.
- R2: The result sign is the XOR of the operand signs. The only exception is NaN, whose sign is 0.
- R3: In single mode with nearest-even rounding, a product of two normal numbers equals the exact significand product after normalisation, rounded to FRAC_W+1 fraction bits with ties going to an even last bit. The result exponent is eA+eB-bias, plus 1 when the significand product is at least 2.
- R4: In extended mode, a product of two normal numbers is exact. The fraction field holds all 2*FRAC_W+1 bits of the normalised significand product below its leading one.
- R5: With truncation selected, the bits dropped below the kept fraction are discarded and the kept bits are never incremented.
- R6: When rounding carries the significand up to 2.0, the fraction becomes zero and the exponent rises by one.
- R7: A result exponent above 2^EXP_W-1 after rounding produces infinity (tag 10) with the product sign.
- R8: A result exponent below 0 after rounding produces zero (tag 00) with the product sign.
- R9: A NaN operand, or a zero multiplied by an infinity in either order, produces NaN (tag 11).
- R10: Apart from the R9 cases, an infinity operand produces infinity.
- R11: Apart from the R9 and R10 cases, a zero operand produces zero.
- R12: The exponent and fraction fields of an operand tagged zero, infinity or NaN have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 3+EXP_W+FRAC_W | First operand word |
| opb_i | input | 3+EXP_W+FRAC_W | Second operand word |
| prod_o | output | 3+EXP_W+OUT_FW | Product word; OUT_FW is FRAC_W+1 or 2*FRAC_W+1 |

## Verification
The bench covers every pair of normal operands of a 4-bit-exponent, 2-bit-fraction format. It drives three builds at once: single with nearest-even rounding, single with truncation, and extended. This covers exact ties, where a design that rounds half away from zero would leave an odd last bit. It also covers fractions of all ones that round up to 2.0, where a design that drops the carry would wrap the fraction to zero without raising the exponent. Exponent sums just past either end of the range are swept too. A design that checks the range before rounding, or that wraps the exponent, would give a wrong normal number in place of infinity or zero. All sixteen tag pairs are crossed with both signs, and the special operands carry non-zero fields. This exposes a wrong priority between NaN, infinity and zero, a wrong NaN sign, and leakage of ignored fields.

// File: rtl/cfp_mul_pkg.sv
package cfp_mul_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_NORM = 2'b01,
    CLS_INF  = 2'b10,
    CLS_NAN  = 2'b11
  } fp_cls_e;

  function automatic int out_frac_w(input int frac_w, input bit extended);
    return extended ? (2 * frac_w + 1) : (frac_w + 1);
  endfunction
endpackage

// File: rtl/cfp_sig_mul.sv
module cfp_sig_mul #(
  parameter int FRAC_W = 3,
  localparam int PW    = 2 * FRAC_W + 2,
  localparam int NFW   = 2 * FRAC_W + 1
) (
  input  logic [FRAC_W-1:0] fa_i,
  input  logic [FRAC_W-1:0] fb_i,
  output logic [NFW-1:0]    nfrac_o,
  output logic              bump_o
);
  logic [PW-1:0] prod;

  always_comb begin
    prod    = {{(FRAC_W+1){1'b0}}, 1'b1, fa_i} * {{(FRAC_W+1){1'b0}}, 1'b1, fb_i};
    bump_o  = prod[PW-1];
    nfrac_o = bump_o ? prod[NFW-1:0] : {prod[NFW-2:0], 1'b0};
  end
endmodule

// File: rtl/cfp_round.sv
module cfp_round #(
  parameter int IN_W     = 7,
  parameter int OUT_W    = 4,
  parameter bit TRUNCATE = 1'b0
) (
  input  logic [IN_W-1:0]  frac_i,
  output logic [OUT_W-1:0] frac_o,
  output logic             carry_o
);
  localparam int DW = IN_W - OUT_W;

  generate
    if (DW <= 0) begin : g_exact
      assign frac_o  = frac_i[IN_W-1 -: OUT_W];
      assign carry_o = 1'b0;
    end else if (TRUNCATE) begin : g_trunc
      logic [DW-1:0] unused_bits;
      assign unused_bits = frac_i[DW-1:0];
      assign frac_o  = frac_i[IN_W-1 -: OUT_W];
      assign carry_o = 1'b0;
    end else begin : g_rne
      logic [OUT_W-1:0] keep;
      logic             guard;
      logic             sticky;
      logic             inc;
      assign keep  = frac_i[IN_W-1 -: OUT_W];
      assign guard = frac_i[DW-1];
      if (DW > 1) begin : g_sticky
        assign sticky = |frac_i[DW-2:0];
      end else begin : g_nosticky
        assign sticky = 1'b0;
      end
      assign inc = guard & (sticky | keep[0]);
      assign {carry_o, frac_o} = {1'b0, keep} + {{OUT_W{1'b0}}, inc};
    end
  endgenerate
endmodule

// File: rtl/cfp_exp_adj.sv
module cfp_exp_adj #(
  parameter int EXP_W = 5,
  localparam int XW   = EXP_W + 2,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic             bump_i,
  input  logic             carry_i,
  output logic [EXP_W-1:0] exp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [XW-1:0] sum;
  logic [XW-1:0] adj;

  always_comb begin
    sum   = {2'b00, ea_i} + {2'b00, eb_i}
          + {{(XW-1){1'b0}}, bump_i} + {{(XW-1){1'b0}}, carry_i};
    unf_o = sum < XW'(BIAS);
    ovf_o = sum > XW'(BIAS + EMAX);
    adj   = sum - XW'(BIAS);
    exp_o = adj[EXP_W-1:0];
  end
endmodule

// File: rtl/cfp_mul.sv
module cfp_mul
  import cfp_mul_pkg::*;
#(
  parameter int EXP_W    = 5,
  parameter int FRAC_W   = 3,
  parameter bit EXTENDED = 1'b0,
  parameter bit TRUNCATE = 1'b0,
  localparam int IN_W    = 3 + EXP_W + FRAC_W,
  localparam int OUT_FW  = EXTENDED ? (2 * FRAC_W + 1) : (FRAC_W + 1),
  localparam int OUT_W   = 3 + EXP_W + OUT_FW,
  localparam int NFW     = 2 * FRAC_W + 1
) (
  input  logic [IN_W-1:0]  opa_i,
  input  logic [IN_W-1:0]  opb_i,
  output logic [OUT_W-1:0] prod_o
);
  fp_cls_e           cls_a, cls_b, cls_o;
  logic              sgn_a, sgn_b, sgn_o;
  logic [EXP_W-1:0]  exp_a, exp_b, exp_n, exp_o;
  logic [FRAC_W-1:0] frc_a, frc_b;
  logic [NFW-1:0]    nfrac;
  logic [OUT_FW-1:0] rfrac, frc_o;
  logic              bump, carry, ovf, unf;

  assign cls_a = fp_cls_e'(opa_i[IN_W-1 -: 2]);
  assign cls_b = fp_cls_e'(opb_i[IN_W-1 -: 2]);
  assign sgn_a = opa_i[EXP_W+FRAC_W];
  assign sgn_b = opb_i[EXP_W+FRAC_W];
  assign exp_a = opa_i[FRAC_W +: EXP_W];
  assign exp_b = opb_i[FRAC_W +: EXP_W];
  assign frc_a = opa_i[FRAC_W-1:0];
  assign frc_b = opb_i[FRAC_W-1:0];

  cfp_sig_mul #(.FRAC_W(FRAC_W)) sig_i (
    .fa_i(frc_a), .fb_i(frc_b), .nfrac_o(nfrac), .bump_o(bump)
  );

  cfp_round #(.IN_W(NFW), .OUT_W(OUT_FW), .TRUNCATE(TRUNCATE)) rnd_i (
    .frac_i(nfrac), .frac_o(rfrac), .carry_o(carry)
  );

  cfp_exp_adj #(.EXP_W(EXP_W)) exp_i (
    .ea_i(exp_a), .eb_i(exp_b), .bump_i(bump), .carry_i(carry),
    .exp_o(exp_n), .ovf_o(ovf), .unf_o(unf)
  );

  always_comb begin
    sgn_o = sgn_a ^ sgn_b;
    exp_o = '0;
    frc_o = '0;
    if ((cls_a == CLS_NAN) || (cls_b == CLS_NAN) ||
        ((cls_a == CLS_ZERO) && (cls_b == CLS_INF)) ||
        ((cls_a == CLS_INF) && (cls_b == CLS_ZERO))) begin
      cls_o = CLS_NAN;
      sgn_o = 1'b0;
    end else if ((cls_a == CLS_INF) || (cls_b == CLS_INF)) begin
      cls_o = CLS_INF;
    end else if ((cls_a == CLS_ZERO) || (cls_b == CLS_ZERO)) begin
      cls_o = CLS_ZERO;
    end else if (ovf) begin
      cls_o = CLS_INF;
    end else if (unf) begin
      cls_o = CLS_ZERO;
    end else begin
      cls_o = CLS_NORM;
      exp_o = exp_n;
      frc_o = rfrac;
    end
  end

  assign prod_o = {cls_o, sgn_o, exp_o, frc_o};
endmodule

// File: rtl/cfp_mul_chk.sv
module cfp_mul_chk #(
  parameter int EXP_W    = 5,
  parameter int FRAC_W   = 3,
  parameter bit EXTENDED = 1'b0,
  localparam int IN_W    = 3 + EXP_W + FRAC_W,
  localparam int OUT_FW  = EXTENDED ? (2 * FRAC_W + 1) : (FRAC_W + 1),
  localparam int OUT_W   = 3 + EXP_W + OUT_FW,
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX    = (1 << EXP_W) - 1
) (
  input logic [IN_W-1:0]  opa_i,
  input logic [IN_W-1:0]  opb_i,
  input logic [OUT_W-1:0] prod_o
);
  logic [1:0] xa, xb, xo;
  logic       sab, so;
  logic       a_nan, b_nan, any_inf, any_zero, both_norm;
  int         esum;

  always_comb begin
    xa        = opa_i[IN_W-1 -: 2];
    xb        = opb_i[IN_W-1 -: 2];
    xo        = prod_o[OUT_W-1 -: 2];
    sab       = opa_i[EXP_W+FRAC_W] ^ opb_i[EXP_W+FRAC_W];
    so        = prod_o[EXP_W+OUT_FW];
    a_nan     = xa == 2'b11;
    b_nan     = xb == 2'b11;
    any_inf   = (xa == 2'b10) || (xb == 2'b10);
    any_zero  = (xa == 2'b00) || (xb == 2'b00);
    both_norm = (xa == 2'b01) && (xb == 2'b01);
    esum      = int'(opa_i[FRAC_W +: EXP_W]) + int'(opb_i[FRAC_W +: EXP_W]) - BIAS;

    if (a_nan || b_nan) begin
      assert_nan_in_R9: assert (xo == 2'b11)
        else $error("NaN operand did not give NaN");
    end
    if (any_inf && any_zero) begin
      assert_zero_inf_R9: assert (xo == 2'b11)
        else $error("zero times infinity did not give NaN");
    end
    if (any_inf && !any_zero && !a_nan && !b_nan) begin
      assert_inf_in_R10: assert (xo == 2'b10)
        else $error("infinity operand did not give infinity");
    end
    if (any_zero && !any_inf && !a_nan && !b_nan) begin
      assert_zero_in_R11: assert (xo == 2'b00)
        else $error("zero operand did not give zero");
    end
    if (xo != 2'b11) begin
      assert_sign_xor_R2: assert (so == sab)
        else $error("result sign is not the XOR of operand signs");
    end else begin
      assert_nan_sign_R2: assert (!so)
        else $error("NaN result has sign set");
    end
    if (xo != 2'b01) begin
      assert_special_clear_R1: assert (prod_o[EXP_W+OUT_FW-1:0] == '0)
        else $error("special result has non-zero fields");
    end
    if (both_norm && (esum >= 0) && (esum <= EMAX - 2)) begin
      assert_in_range_R3: assert (xo == 2'b01)
        else $error("in-range normal product not normal");
    end
    if (both_norm && (opa_i[FRAC_W-1:0] == '0) && (opb_i[FRAC_W-1:0] == '0)) begin
      assert_unit_frac_R4: assert (prod_o[OUT_FW-1:0] == '0)
        else $error("product of unit significands has non-zero fraction");
    end
  end
endmodule

bind cfp_mul cfp_mul_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXTENDED(EXTENDED)
) chk_i (
  .opa_i(opa_i), .opb_i(opb_i), .prod_o(prod_o)
);

// File: tb/cfp_mul_tb_top.sv
module cfp_mul_tb_top;
  localparam int WE   = 4;
  localparam int WF   = 2;
  localparam int IW   = 3 + WE + WF;
  localparam int SFW  = WF + 1;
  localparam int EFW  = 2 * WF + 1;
  localparam int SOW  = 3 + WE + SFW;
  localparam int EOW  = 3 + WE + EFW;
  localparam int BIAS = (1 << (WE - 1)) - 1;
  localparam int EMAX = (1 << WE) - 1;

  logic clk;
  logic [IW-1:0]  opa, opb;
  logic [SOW-1:0] p_sn, p_tz;
  logic [EOW-1:0] p_ex;
  int total = 0;
  int bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  cfp_mul #(.EXP_W(WE), .FRAC_W(WF), .EXTENDED(1'b0), .TRUNCATE(1'b0)) dut_i (
    .opa_i(opa), .opb_i(opb), .prod_o(p_sn));
  cfp_mul #(.EXP_W(WE), .FRAC_W(WF), .EXTENDED(1'b1), .TRUNCATE(1'b0)) dut_ext_i (
    .opa_i(opa), .opb_i(opb), .prod_o(p_ex));
  cfp_mul #(.EXP_W(WE), .FRAC_W(WF), .EXTENDED(1'b0), .TRUNCATE(1'b1)) dut_rtz_i (
    .opa_i(opa), .opb_i(opb), .prod_o(p_tz));

  // Requirement classes: R3 rounded, R4 extended, R5 truncated, R6 carry,
  // R7 overflow, R8 underflow, R9 NaN, R10 infinity, R11 zero.
  function automatic int model(input int a, input int b, input int wfo,
                               input bit rtz, output int req);
    int xa, sa, ea, fa, xb, sb, eb, fb;
    int s, x, e, f, p, fr, q, rem;
    xa = (a >> (1 + WE + WF)) & 3; sa = (a >> (WE + WF)) & 1;
    ea = (a >> WF) & EMAX;         fa = a & ((1 << WF) - 1);
    xb = (b >> (1 + WE + WF)) & 3; sb = (b >> (WE + WF)) & 1;
    eb = (b >> WF) & EMAX;         fb = b & ((1 << WF) - 1);
    s = sa ^ sb; e = 0; f = 0;
    if (xa == 3 || xb == 3 || (xa == 0 && xb == 2) || (xa == 2 && xb == 0)) begin
      x = 3; s = 0; req = 9;
    end else if (xa == 2 || xb == 2) begin
      x = 2; req = 10;
    end else if (xa == 0 || xb == 0) begin
      x = 0; req = 11;
    end else begin
      p = ((1 << WF) + fa) * ((1 << WF) + fb);
      e = ea + eb - BIAS;
      if (p >= (2 << (2 * WF))) begin
        e = e + 1; fr = p - (2 << (2 * WF));
      end else begin
        fr = (p - (1 << (2 * WF))) * 2;
      end
      if (wfo == EFW) begin
        f = fr; req = 4;
      end else begin
        q = fr >> (EFW - wfo); rem = fr & ((1 << (EFW - wfo)) - 1);
        req = rtz ? 5 : 3;
        if (!rtz && (rem > (1 << (EFW - wfo - 1)) ||
                     (rem == (1 << (EFW - wfo - 1)) && (q % 2) == 1))) q = q + 1;
        if (q == (1 << wfo)) begin
          q = 0; e = e + 1; req = 6;
        end
        f = q;
      end
      if (e > EMAX) begin
        x = 2; e = 0; f = 0; req = 7;
      end else if (e < 0) begin
        x = 0; e = 0; f = 0; req = 8;
      end else begin
        x = 1;
      end
    end
    return (x << (1 + WE + wfo)) | (s << (WE + wfo)) | (e << wfo) | f;
  endfunction

  task automatic check(input int got, input int exp, input int req, input string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL R%0d %s a=%h b=%h got=%h exp=%h", req, what, opa, opb, got, exp);
    end
  endtask

  task automatic apply_and_check(input int a, input int b);
    int req, e_sn, e_ex, e_tz;
    @(posedge clk);
    opa = IW'(a); opb = IW'(b);
    @(negedge clk);
    e_sn = model(a, b, SFW, 1'b0, req);
    check(int'(p_sn), e_sn, req, "single/nearest-even");
    e_ex = model(a, b, EFW, 1'b0, req);
    check(int'(p_ex), e_ex, req, "extended");
    e_tz = model(a, b, SFW, 1'b1, req);
    check(int'(p_tz), e_tz, req, "single/truncate");
    // R2: sign bit on its own
    check(int'(p_sn[WE+SFW]), (e_sn >> (WE + SFW)) & 1, 2, "sign");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    opa = '0; opb = '0;
    // R1: word widths
    total++;
    if ($bits(p_sn) != 3 + WE + WF + 1 || $bits(p_ex) != 3 + WE + 2 * WF + 1) begin
      bad++;
      $display("FAIL R1 widths got=%0d/%0d exp=%0d/%0d", $bits(p_sn), $bits(p_ex),
               3 + WE + WF + 1, 3 + WE + 2 * WF + 1);
    end
    // R3 R4 R5 R6 R7 R8: all normal operand pairs
    for (int a = 0; a < (1 << (1 + WE + WF)); a++) begin
      for (int b = 0; b < (1 << (1 + WE + WF)); b++) begin
        apply_and_check((1 << (1 + WE + WF)) | a, (1 << (1 + WE + WF)) | b);
      end
    end
    // R9 R10 R11 R12: every tag pair, both signs, non-zero ignored fields
    for (int xa = 0; xa < 4; xa++)
      for (int xb = 0; xb < 4; xb++)
        for (int sa = 0; sa < 2; sa++)
          for (int sb = 0; sb < 2; sb++) begin
            apply_and_check((xa << (1 + WE + WF)) | (sa << (WE + WF)) | (11 << WF) | 2,
                            (xb << (1 + WE + WF)) | (sb << (WE + WF)) | (5 << WF) | 3);
          end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule